// File: doc/BRIEF.md
# Stream Channel Interrupt Generator

This block turns the fill levels of up to eight receive and eight transmit channel FIFOs into two interrupt requests, one for the receive side and one for the transmit side. Software programs one 32-bit configuration word. For every channel the word holds an enable bit and a condition-select bit. The condition-select bit picks one of two tests for the channel: a half-depth threshold, or a test against the FIFO edge (not empty for receive, not full for transmit).

Each channel's selected test is gated by its enable bit. All gated receive results are ORed into one registered receive request, and all gated transmit results into one registered transmit request. For each request, a one-cycle pulse output marks the cycle in which the request rises, so that an edge-triggered interrupt input can also be served.

When a FIFO side is built with depth one, its condition-select bits are fixed to the edge test. Bits of channels that are not built read as zero. The FIFOs, the data path and the interrupt controller lie outside this block.

Top module: `stream_irq_gen`

## Requirements
- R1: Configuration bits 7:0 enable receive channels 0..7, and bits 23:16 enable transmit channels 0..7. Channel k uses bit k of its field.
- R2: Receive condition select is bit 8+k for channel k. Value 0 tests `rx_level >= RX_DEPTH/2` (integer division). Value 1 tests `rx_level != 0`.
- R3: Transmit condition select is bit 24+k for channel k. Value 0 tests `tx_level < TX_DEPTH/2`. Value 1 tests `tx_level != TX_DEPTH`.
- R4: `rx_irq` is registered. After a clock edge it is high exactly when, before that edge, at least one enabled receive channel met its selected test. `tx_irq` behaves the same way for the transmit channels.
- R5: A channel whose enable bit is 0 never causes a request, whatever its level.
- R6: If RX_DEPTH is 1, the receive select bits of the built channels read as 1, ignore writes, and apply the not-empty test. TX_DEPTH equal to 1 does the same for the transmit select bits, with the not-full test.
- R7: Enable and select bits of channels at or above N_RX (receive) or N_TX (transmit) read as 0 and ignore writes.
- R8: While `rst_n` is low, all stored configuration bits are 0 and `rx_irq`, `tx_irq` and both pulse outputs are low.
- R9: A write takes effect at a clock edge where `bus_we` is high and `bus_addr` equals CFG_WORD. A write to any other address leaves the configuration unchanged. `bus_rdata` shows the configuration combinationally while `bus_addr` equals CFG_WORD, and shows 0 at any other address.
- R10: `rx_irq_pulse` is high for one cycle, exactly in the first cycle where `rx_irq` is high after being low. `tx_irq_pulse` does the same for `tx_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Word address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data; configuration word when addressed, 0 otherwise |
| rx_level | input | N_RX*clog2(RX_DEPTH+1) | Receive FIFO fill counts, channel k in slice k |
| tx_level | input | N_TX*clog2(TX_DEPTH+1) | Transmit FIFO fill counts, channel k in slice k |
| rx_irq | output | 1 | Registered receive interrupt request level |
| tx_irq | output | 1 | Registered transmit interrupt request level |
| rx_irq_pulse | output | 1 | One-cycle pulse when rx_irq rises |
| tx_irq_pulse | output | 1 | One-cycle pulse when tx_irq rises |

## Verification
A wrong configuration bit shows in two places. It shows on `bus_rdata` in the same cycle the word is addressed, and it shows on a request output one edge after a fill level makes the bad bit matter. A wrong threshold or test shows as a wrong `rx_irq` or `tx_irq` one edge after the level crosses the boundary, so the bench drives each half-depth and edge boundary from both sides. A stale request register shows as a missing or doubled pulse in the same cycle as the request's rising edge.

// File: rtl/stream_irq_pkg.sv
package stream_irq_pkg;

  localparam int MAX_CH = 8;
  localparam int REG_W  = 32;

  // Field order inside the word is fixed: software decodes these positions.
  typedef struct packed {
    logic [MAX_CH-1:0] tx_mode;
    logic [MAX_CH-1:0] tx_en;
    logic [MAX_CH-1:0] rx_mode;
    logic [MAX_CH-1:0] rx_en;
  } irq_cfg_t;

  function automatic logic [MAX_CH-1:0] ch_mask(input int n);
    logic [MAX_CH-1:0] m;
    m = '0;
    for (int i = 0; i < MAX_CH; i++) begin
      if (i < n) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/stream_irq_cfg.sv
module stream_irq_cfg
  import stream_irq_pkg::*;
#(
  parameter int N_RX     = 8,
  parameter int N_TX     = 8,
  parameter int RX_DEPTH = 8,
  parameter int TX_DEPTH = 8,
  parameter int ADDR_W   = 4,
  parameter int CFG_WORD = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output irq_cfg_t          cfg_q,
  output irq_cfg_t          cfg_eff
);

  localparam logic [MAX_CH-1:0] RX_CH = ch_mask(N_RX);
  localparam logic [MAX_CH-1:0] TX_CH = ch_mask(N_TX);
  localparam irq_cfg_t IMPL = '{tx_mode: TX_CH, tx_en: TX_CH,
                                rx_mode: RX_CH, rx_en: RX_CH};
  localparam irq_cfg_t FORCE = '{tx_mode: (TX_DEPTH == 1) ? TX_CH : '0,
                                 tx_en:   '0,
                                 rx_mode: (RX_DEPTH == 1) ? RX_CH : '0,
                                 rx_en:   '0};
  localparam logic [REG_W-1:0]  WMASK = IMPL & ~FORCE;
  localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(CFG_WORD);

  logic     hit;
  logic     wr_en;
  irq_cfg_t cfg_d;

  // next state
  always_comb begin
    hit   = (bus_addr == CFG_A);
    wr_en = hit & bus_we;
    cfg_d = irq_cfg_t'(bus_wdata & WMASK);
  end

  // register with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_en) begin
      cfg_q <= cfg_d;
    end
  end

  // forced select bits are merged on the output side
  always_comb begin
    cfg_eff   = irq_cfg_t'(cfg_q | FORCE);
    bus_rdata = hit ? REG_W'(cfg_eff) : '0;
  end

endmodule

// File: rtl/stream_irq_cond.sv
module stream_irq_cond #(
  parameter int N_CH  = 8,
  parameter int DEPTH = 8,
  parameter bit IS_TX = 1'b0,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic [N_CH*CW-1:0] level,
  input  logic [N_CH-1:0]    en,
  input  logic [N_CH-1:0]    mode,
  output logic               any_o
);

  localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [N_CH-1:0] met;

  if (DEPTH == 1) begin : g_single_unused
    // depth one has no threshold; select bits carry no information here
    logic unused_mode;
    assign unused_mode = ^mode;
  end

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic [CW-1:0] lv;
    assign lv = level[i*CW +: CW];

    if (DEPTH == 1) begin : g_edge_only
      if (IS_TX) begin : g_tx
        assign met[i] = en[i] & (lv != FULL);
      end else begin : g_rx
        assign met[i] = en[i] & (lv != '0);
      end
    end else begin : g_select
      if (IS_TX) begin : g_tx
        assign met[i] = en[i] & (mode[i] ? (lv != FULL) : (lv < HALF));
      end else begin : g_rx
        assign met[i] = en[i] & (mode[i] ? (lv != '0) : (lv >= HALF));
      end
    end
  end

  assign any_o = |met;

endmodule

// File: rtl/stream_irq_req.sv
module stream_irq_req (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic level_o,
  output logic pulse_o
);

  logic level_d;
  logic pulse_d;

  always_comb begin
    level_d = req_i;
    pulse_d = req_i & ~level_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_o <= 1'b0;
      pulse_o <= 1'b0;
    end else begin
      level_o <= level_d;
      pulse_o <= pulse_d;
    end
  end

endmodule

// File: rtl/stream_irq_gen.sv
module stream_irq_gen
  import stream_irq_pkg::*;
#(
  parameter int N_RX     = 8,
  parameter int N_TX     = 8,
  parameter int RX_DEPTH = 8,
  parameter int TX_DEPTH = 8,
  parameter int ADDR_W   = 4,
  parameter int CFG_WORD = 2,
  localparam int RX_CW   = $clog2(RX_DEPTH + 1),
  localparam int TX_CW   = $clog2(TX_DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_we,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [N_RX*RX_CW-1:0] rx_level,
  input  logic [N_TX*TX_CW-1:0] tx_level,
  output logic                  rx_irq,
  output logic                  tx_irq,
  output logic                  rx_irq_pulse,
  output logic                  tx_irq_pulse
);

  irq_cfg_t cfg_stored;
  irq_cfg_t cfg_eff;
  logic     rx_any;
  logic     tx_any;

  stream_irq_cfg #(
    .N_RX(N_RX), .N_TX(N_TX), .RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH),
    .ADDR_W(ADDR_W), .CFG_WORD(CFG_WORD)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cfg_q     (cfg_stored),
    .cfg_eff   (cfg_eff)
  );

  stream_irq_cond #(.N_CH(N_RX), .DEPTH(RX_DEPTH), .IS_TX(1'b0)) u_rx_cond (
    .level (rx_level),
    .en    (cfg_eff.rx_en[N_RX-1:0]),
    .mode  (cfg_eff.rx_mode[N_RX-1:0]),
    .any_o (rx_any)
  );

  stream_irq_cond #(.N_CH(N_TX), .DEPTH(TX_DEPTH), .IS_TX(1'b1)) u_tx_cond (
    .level (tx_level),
    .en    (cfg_eff.tx_en[N_TX-1:0]),
    .mode  (cfg_eff.tx_mode[N_TX-1:0]),
    .any_o (tx_any)
  );

  stream_irq_req u_rx_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (rx_any),
    .level_o (rx_irq),
    .pulse_o (rx_irq_pulse)
  );

  stream_irq_req u_tx_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (tx_any),
    .level_o (tx_irq),
    .pulse_o (tx_irq_pulse)
  );

  // upper slices of the config are meaningful only for larger channel counts
  logic unused_cfg;
  assign unused_cfg = ^{cfg_eff, cfg_stored};

endmodule

// File: rtl/stream_irq_chk.sv
module stream_irq_chk
  import stream_irq_pkg::*;
#(
  parameter int N_RX     = 8,
  parameter int N_TX     = 8,
  parameter int RX_DEPTH = 8,
  parameter int TX_DEPTH = 8,
  parameter int ADDR_W   = 4,
  parameter int CFG_WORD = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [31:0]       bus_rdata,
  input irq_cfg_t          cfg_q,
  input logic              rx_irq,
  input logic              tx_irq,
  input logic              rx_irq_pulse,
  input logic              tx_irq_pulse
);

  localparam logic [ADDR_W-1:0] A = ADDR_W'(CFG_WORD);
  localparam logic [7:0] RXM = ch_mask(N_RX);
  localparam logic [7:0] TXM = ch_mask(N_TX);
  localparam logic [31:0] BUILT = {TXM, TXM, RXM, RXM};

  // R8: quiet outputs while reset is held
  p_reset_quiet_r8: assert property (@(posedge clk)
    !rst_n |-> (!rx_irq && !tx_irq && !rx_irq_pulse && !tx_irq_pulse));

  // R5: nothing enabled means no request after the next edge
  p_rx_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.rx_en == '0) |=> !rx_irq);
  p_tx_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.tx_en == '0) |=> !tx_irq);

  // R9: no addressed write, no change
  p_hold_cfg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == A) |=> $stable(cfg_q));

  // R7: unbuilt channel bits read zero
  p_unbuilt_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~BUILT) == 32'h0);

  // R10: pulse only in the first high cycle of the request
  p_rx_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq_pulse |-> (rx_irq && !$past(rx_irq)));
  p_tx_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq_pulse |-> (tx_irq && !$past(tx_irq)));
  p_rx_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_irq) |-> rx_irq_pulse);
  p_tx_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_irq) |-> tx_irq_pulse);

  // R6: depth-one sides read their select bits as one
  if (RX_DEPTH == 1) begin : g_rx_single
    p_rx_forced_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == A) |-> ((bus_rdata[15:8] & RXM) == RXM));
  end
  if (TX_DEPTH == 1) begin : g_tx_single
    p_tx_forced_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == A) |-> ((bus_rdata[31:24] & TXM) == TXM));
  end

endmodule

bind stream_irq_gen stream_irq_chk #(
  .N_RX(N_RX), .N_TX(N_TX), .RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH),
  .ADDR_W(ADDR_W), .CFG_WORD(CFG_WORD)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_addr     (bus_addr),
  .bus_we       (bus_we),
  .bus_rdata    (bus_rdata),
  .cfg_q        (cfg_stored),
  .rx_irq       (rx_irq),
  .tx_irq       (tx_irq),
  .rx_irq_pulse (rx_irq_pulse),
  .tx_irq_pulse (tx_irq_pulse)
);

// File: tb/stream_irq_gen_test.sv
`timescale 1ns/100ps
module stream_irq_gen_test;

  localparam int AW  = 4;
  localparam int CFG = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   rdata_a, rdata_b;
  logic [23:0]   rx_lvl_a = '0;
  logic [7:0]    tx_lvl_a = '0;
  logic [7:0]    rx_lvl_b = '0;
  logic [14:0]   tx_lvl_b = '0;
  logic rx_a, tx_a, rxp_a, txp_a, rx_b, tx_b, rxp_b, txp_b;

  // variant a: 6 RX deep 8, 8 TX depth 1
  stream_irq_gen #(.N_RX(6), .N_TX(8), .RX_DEPTH(8), .TX_DEPTH(1),
                   .ADDR_W(AW), .CFG_WORD(CFG)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .rx_level(rx_lvl_a),
    .tx_level(tx_lvl_a), .rx_irq(rx_a), .tx_irq(tx_a),
    .rx_irq_pulse(rxp_a), .tx_irq_pulse(txp_a));

  // variant b: 8 RX depth 1, 5 TX deep 4
  stream_irq_gen #(.N_RX(8), .N_TX(5), .RX_DEPTH(1), .TX_DEPTH(4),
                   .ADDR_W(AW), .CFG_WORD(CFG)) uut_b (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .rx_level(rx_lvl_b),
    .tx_level(tx_lvl_b), .rx_irq(rx_b), .tx_irq(tx_b),
    .rx_irq_pulse(rxp_b), .tx_irq_pulse(txp_b));

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;
  int rxa[8], txa[8], rxb[8], txb[8];
  logic [31:0] st_a = '0, st_b = '0;
  logic [3:0]  prev = '0;  // {tx_b, rx_b, tx_a, rx_a}

  function automatic logic [7:0] chm(input int n);
    logic [7:0] m = '0;
    for (int i = 0; i < 8; i++) if (i < n) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [31:0] built(input int nrx, input int ntx);
    return {chm(ntx), chm(ntx), chm(nrx), chm(nrx)};
  endfunction

  function automatic logic [31:0] forced(input int nrx, input int ntx,
                                         input int rxd, input int txd);
    return {(txd == 1) ? chm(ntx) : 8'h00, 8'h00,
            (rxd == 1) ? chm(nrx) : 8'h00, 8'h00};
  endfunction

  function automatic logic exp_rx(input logic [31:0] c, input int lv[8],
                                  input int n, input int d);
    logic r = 1'b0;
    for (int i = 0; i < n; i++)
      if (c[i] && (c[8+i] ? (lv[i] != 0) : (lv[i] >= d / 2))) r = 1'b1;
    return r;
  endfunction

  function automatic logic exp_tx(input logic [31:0] c, input int lv[8],
                                  input int n, input int d);
    logic r = 1'b0;
    for (int i = 0; i < n; i++)
      if (c[16+i] && (c[24+i] ? (lv[i] != d) : (lv[i] < d / 2))) r = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] vis_a();
    return st_a | forced(6, 8, 8, 1);
  endfunction
  function automatic logic [31:0] vis_b();
    return st_b | forced(8, 5, 1, 4);
  endfunction

  function automatic logic [3:0] exp_all();
    return {exp_tx(vis_b(), txb, 5, 4), exp_rx(vis_b(), rxb, 8, 1),
            exp_tx(vis_a(), txa, 8, 1), exp_rx(vis_a(), rxa, 6, 8)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
  endtask

  task automatic drive_levels();
    for (int i = 0; i < 8; i++) begin
      if (i < 6) rx_lvl_a[i*4 +: 4] = 4'(rxa[i]);
      tx_lvl_a[i] = 1'(txa[i]);
      rx_lvl_b[i] = 1'(rxb[i]);
      if (i < 5) tx_lvl_b[i*3 +: 3] = 3'(txb[i]);
    end
  endtask

  task automatic fill(input int ra, input int ta, input int rb, input int tb);
    for (int i = 0; i < 8; i++) begin
      rxa[i] = ra; txa[i] = ta; rxb[i] = rb; txb[i] = tb;
    end
  endtask

  // apply levels at a falling edge, sample after one rising edge
  task automatic apply(input string tag);
    logic [3:0] e;
    drive_levels();
    @(posedge clk);
    @(negedge clk);
    e = exp_all();
    chk({tag, " rx_a"}, 32'(rx_a), 32'(e[0]));
    chk({tag, " tx_a"}, 32'(tx_a), 32'(e[1]));
    chk({tag, " rx_b"}, 32'(rx_b), 32'(e[2]));
    chk({tag, " tx_b"}, 32'(tx_b), 32'(e[3]));
    chk("R10 pulses", 32'({txp_b, rxp_b, txp_a, rxp_a}), 32'(e & ~prev));
    prev = e;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
    if (a == AW'(CFG)) begin
      st_a = d & built(6, 8) & ~forced(6, 8, 8, 1);
      st_b = d & built(8, 5) & ~forced(8, 5, 1, 4);
    end
    @(posedge clk);
    @(negedge clk);
    prev = exp_all();
    bus_addr = AW'(CFG);
  endtask

  task automatic rd(input string tag, input logic [AW-1:0] a);
    bus_addr = a;
    #1;
    chk({tag, " rdata_a"}, rdata_a, (a == AW'(CFG)) ? vis_a() : 32'h0);
    chk({tag, " rdata_b"}, rdata_b, (a == AW'(CFG)) ? vis_b() : 32'h0);
    bus_addr = AW'(CFG);
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_err++;
      $display("FAIL R4 watchdog act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    fill(0, 0, 0, 0);
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R8: outputs quiet during reset
    chk("R8 reset outputs", 32'({rx_a, tx_a, rxp_a, txp_a, rx_b, tx_b, rxp_b, txp_b}), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    bus_addr = AW'(CFG);
    rd("R8 reset cfg", AW'(CFG));
    fill(8, 1, 1, 4);
    apply("R8 enables clear");

    // R1 R7: every bit written, unbuilt channels read zero
    wr(AW'(CFG), 32'hFFFF_FFFF);
    rd("R7 all-ones", AW'(CFG));
    chk("R7 a rx high bits", 32'(rdata_a[7:6]), 32'h0);
    chk("R7 b tx high bits", 32'(rdata_b[23:21]), 32'h0);

    // R6: select bits of depth-one sides stay one after writing zero
    wr(AW'(CFG), 32'h00FF_00FF);
    rd("R6 forced modes", AW'(CFG));
    chk("R6 a tx mode", 32'(rdata_a[31:24]), 32'hFF);
    chk("R6 b rx mode", 32'(rdata_b[15:8]), 32'hFF);

    // R2 threshold mode on a (depth 8, half = 4), R3 threshold on b (depth 4, half = 2)
    // R6 not-full on a tx, not-empty on b rx
    fill(0, 1, 0, 2);
    apply("R2 R3 R6 all quiet");
    rxa[5] = 3; apply("R2 below half");
    rxa[5] = 4; apply("R2 at half");
    txa[7] = 0; apply("R6 tx not full");
    rxb[7] = 1; apply("R6 rx not empty");
    txb[4] = 1; apply("R3 below half");
    fill(0, 1, 0, 2);
    apply("R10 all fall");

    // R2 R3 edge modes
    wr(AW'(CFG), 32'hFFFF_FFFF);
    fill(0, 1, 0, 4);
    apply("R2 R3 edge quiet");
    rxa[0] = 1; apply("R2 not empty");
    txb[2] = 3; apply("R3 not full");

    // R1 R5: only channel 3 enabled
    wr(AW'(CFG), 32'h0808_0808);
    fill(8, 0, 1, 0);
    rxa[3] = 0; txa[3] = 1; rxb[3] = 0; txb[3] = 4;
    apply("R5 others disabled");
    rxa[3] = 1; txa[3] = 0; rxb[3] = 1; txb[3] = 3;
    apply("R1 channel 3");

    // R9: other address is neither written nor read
    wr(AW'(5), 32'h0000_0000);
    rd("R9 unchanged", AW'(CFG));
    rd("R9 other addr", AW'(5));
    apply("R9 requests kept");

    // R4: random levels and configurations
    for (int it = 0; it < 600; it++) begin
      if (it % 40 == 0) wr(AW'(CFG), $urandom);
      for (int i = 0; i < 8; i++) begin
        rxa[i] = $urandom_range(0, 8);
        txa[i] = $urandom_range(0, 1);
        rxb[i] = $urandom_range(0, 1);
        txb[i] = $urandom_range(0, 4);
      end
      apply("R4 random");
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule